// File: doc/BRIEF.md
# Nestable Priority Interrupt Controller

This block arbitrates the interrupt requests of a small CPU core across 32 vectors. Each vector has its own enable bit, a 3-bit priority that software can change while the system runs, a programmable handler address, and a selector that routes one of three request groups into it: fixed-function lines, DMA lines or general routed lines. A rising edge on the selected line marks the vector pending. Software can also set a vector pending or clear it through a single write port.

Each cycle the controller picks the most urgent vector that is both pending and enabled. It presents that vector's number, priority and handler address to the CPU, but only when the vector outranks the level that is currently running. When the CPU acknowledges, the vector's pending bit is cleared and its priority is pushed onto an eight-entry stack of active levels. A return indication from the CPU pops that stack, so the interrupted level resumes arbitration. Saving the program counter is the CPU's job.

Top module: `nest_vic`

## Requirements
- R1: After reset no vector is enabled or pending, every priority is 7, every source selector is "none", every handler address is 0, the active-level stack is empty and `irq_req` is low.
- R2: A vector that becomes pending while disabled raises no request, stays pending, and raises a request once it is enabled.
- R3: Among pending, enabled vectors, the one with the numerically smallest priority is presented; priority 0 is the most urgent.
- R4: When several candidates share the best priority, the lowest vector number is presented.
- R5: A priority rewrite changes arbitration from the cycle after the write.
- R6: `irq_addr` equals the handler address last written for the presented vector, and `irq_prio` equals its priority.
- R7: Source selector codes are 0 fixed-function, 1 DMA, 2 routed and 3 none. Only a rising edge on the selected line sets pending. A line held high does not set pending again, and lines of unselected groups have no effect.
- R8: Software set-pending and clear-pending act on the indexed vector. A clear in the same cycle as a set or a source edge wins.
- R9: An acknowledge while `irq_req` is high clears the presented vector's pending bit and pushes its priority. An acknowledge while `irq_req` is low has no effect.
- R10: A request is presented only when the stack is empty or the candidate's priority is strictly smaller than the top of the stack. An equal priority does not preempt.
- R11: A return pops one stack level, and lower levels resume arbitration. A return with an empty stack is ignored. When a return and an acknowledge arrive in the same cycle, the return acts and the acknowledge is ignored.
- R12: Nesting reaches eight levels, one per distinct priority.
- R13: Write codes on `cfg_field` are 0 enable (`cfg_data[0]`), 1 priority (`cfg_data[2:0]`), 2 source selector (`cfg_data[1:0]`), 3 set pending, 4 clear pending and 5 handler address (`cfg_data`). Each write takes effect in the cycle after `cfg_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_fixed | input | 32 | Fixed-function request lines, one per vector |
| src_dma | input | 32 | DMA request lines, one per vector |
| src_routed | input | 32 | Routed digital request lines, one per vector |
| cfg_we | input | 1 | Write strobe |
| cfg_field | input | 3 | Write code (see R13) |
| cfg_idx | input | 5 | Target vector |
| cfg_data | input | 16 | Write data |
| ack | input | 1 | CPU takes the presented vector |
| reti | input | 1 | CPU finished the current handler |
| irq_req | output | 1 | A vector outranks the active level |
| irq_vec | output | 5 | Presented vector number |
| irq_prio | output | 3 | Presented vector priority |
| irq_addr | output | 16 | Presented handler address |

## Verification
Requests are raised through each source group in turn. Lines are also toggled on unselected groups and held high, which separates true edge detection from level sensing and shows whether the selector really gates each group. Several vectors are made pending at once with mixed and tied priorities, and one priority is rewritten in the middle of the run, which tells priority ordering apart from index ordering. A climb to eight nested levels is then unwound, along with equal-priority arrivals and a return that lands together with an acknowledge. These show whether the preemption test is strict and whether lower levels resume after each return.

// File: rtl/nvic_pkg.sv
package nvic_pkg;
  typedef enum logic [2:0] {
    FLD_ENABLE = 3'd0,
    FLD_PRIO   = 3'd1,
    FLD_SRC    = 3'd2,
    FLD_SETP   = 3'd3,
    FLD_CLRP   = 3'd4,
    FLD_ADDR   = 3'd5
  } cfg_field_e;

  typedef enum logic [1:0] {
    SRC_FIXED  = 2'd0,
    SRC_DMA    = 2'd1,
    SRC_ROUTED = 2'd2,
    SRC_NONE   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/nvic_pend_bank.sv
module nvic_pend_bank
  import nvic_pkg::*;
#(
  parameter int NVEC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] src_fixed,
  input  logic [NVEC-1:0] src_dma,
  input  logic [NVEC-1:0] src_routed,
  input  src_sel_e        sel [NVEC],
  input  logic [NVEC-1:0] set_mask,
  input  logic [NVEC-1:0] clr_mask,
  input  logic [NVEC-1:0] ack_mask,
  output logic [NVEC-1:0] pend
);
  logic [NVEC-1:0] line;
  logic [NVEC-1:0] prev_q;
  logic [NVEC-1:0] pend_d;

  for (genvar i = 0; i < NVEC; i++) begin : g_vec
    always_comb begin
      unique case (sel[i])
        SRC_FIXED:  line[i] = src_fixed[i];
        SRC_DMA:    line[i] = src_dma[i];
        SRC_ROUTED: line[i] = src_routed[i];
        default:    line[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    pend_d = ((pend & ~ack_mask) | (line & ~prev_q) | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= line;
      pend   <= pend_d;
    end
  end
endmodule

// File: rtl/nvic_arbiter.sv
module nvic_arbiter #(
  parameter int NVEC = 32,
  parameter int PW   = 3,
  localparam int VW  = $clog2(NVEC)
) (
  input  logic [NVEC-1:0] cand,
  input  logic [PW-1:0]   prio [NVEC],
  output logic            found,
  output logic [VW-1:0]   best_idx,
  output logic [PW-1:0]   best_prio
);
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    for (int i = 0; i < NVEC; i++) begin
      if (cand[i] && (!found || (prio[i] < best_prio))) begin
        found     = 1'b1;
        best_idx  = VW'(i);
        best_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/nvic_level_stack.sv
module nvic_level_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_prio,
  input  logic          pop,
  output logic [CW-1:0] depth,
  output logic          empty,
  output logic [PW-1:0] top_prio
);
  logic [PW-1:0] stk_q [DEPTH];
  logic [PW-1:0] stk_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    stk_d = stk_q;
    if (pop && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end else if (push && (cnt_q < CW'(DEPTH))) begin
      stk_d[cnt_q[$clog2(DEPTH)-1:0]] = push_prio;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      stk_q <= stk_d;
    end
  end

  assign depth    = cnt_q;
  assign empty    = (cnt_q == '0);
  assign top_prio = empty ? '1 : stk_q[$clog2(DEPTH)'(cnt_q - 1'b1)];
endmodule

// File: rtl/nest_vic.sv
module nest_vic
  import nvic_pkg::*;
#(
  parameter int NVEC   = 32,
  parameter int NPRIO  = 8,
  parameter int DEPTH  = 8,
  parameter int AW     = 16,
  localparam int VW    = $clog2(NVEC),
  localparam int PW    = $clog2(NPRIO),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] src_fixed,
  input  logic [NVEC-1:0] src_dma,
  input  logic [NVEC-1:0] src_routed,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_field,
  input  logic [VW-1:0]   cfg_idx,
  input  logic [AW-1:0]   cfg_data,
  input  logic            ack,
  input  logic            reti,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec,
  output logic [PW-1:0]   irq_prio,
  output logic [AW-1:0]   irq_addr
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // per-vector configuration
  logic [NVEC-1:0] en_q, en_d;
  logic [PW-1:0]   prio_q [NVEC];
  logic [PW-1:0]   prio_d [NVEC];
  src_sel_e        sel_q  [NVEC];
  src_sel_e        sel_d  [NVEC];
  logic [AW-1:0]   addr_q [NVEC];
  logic [AW-1:0]   addr_d [NVEC];
  logic [NVEC-1:0] set_mask, clr_mask, ack_mask;
  logic [NVEC-1:0] hit;

  always_comb begin
    hit      = '0;
    hit[cfg_idx] = cfg_we;
    en_d     = en_q;
    prio_d   = prio_q;
    sel_d    = sel_q;
    addr_d   = addr_q;
    set_mask = '0;
    clr_mask = '0;
    if (cfg_we) begin
      unique case (cfg_field)
        FLD_ENABLE: en_d[cfg_idx]   = cfg_data[0];
        FLD_PRIO:   prio_d[cfg_idx] = cfg_data[PW-1:0];
        FLD_SRC:    sel_d[cfg_idx]  = src_sel_e'(cfg_data[1:0]);
        FLD_SETP:   set_mask        = hit;
        FLD_CLRP:   clr_mask        = hit;
        FLD_ADDR:   addr_d[cfg_idx] = cfg_data;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q <= '0;
      for (int i = 0; i < NVEC; i++) begin
        prio_q[i] <= '1;
        sel_q[i]  <= SRC_NONE;
        addr_q[i] <= '0;
      end
    end else if (cfg_we) begin
      en_q   <= en_d;
      prio_q <= prio_d;
      sel_q  <= sel_d;
      addr_q <= addr_d;
    end
  end

  // pending capture
  logic [NVEC-1:0] pend_q;

  nvic_pend_bank #(.NVEC(NVEC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .src_fixed  (src_fixed),
    .src_dma    (src_dma),
    .src_routed (src_routed),
    .sel        (sel_q),
    .set_mask   (set_mask),
    .clr_mask   (clr_mask),
    .ack_mask   (ack_mask),
    .pend       (pend_q)
  );

  // selection
  logic          found;
  logic [VW-1:0] best_idx;
  logic [PW-1:0] best_prio;

  nvic_arbiter #(.NVEC(NVEC), .PW(PW)) u_arb (
    .cand      (pend_q & en_q),
    .prio      (prio_q),
    .found     (found),
    .best_idx  (best_idx),
    .best_prio (best_prio)
  );

  // active level tracking
  logic          stk_empty;
  logic [PW-1:0] top_prio;
  logic [CW-1:0] act_depth;
  logic          take;

  assign irq_req = found && (stk_empty || (best_prio < top_prio));
  assign take    = ack && irq_req && !reti;

  always_comb begin
    ack_mask = '0;
    ack_mask[best_idx] = take;
  end

  nvic_level_stack #(.DEPTH(DEPTH), .PW(PW)) u_stk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (take),
    .push_prio (best_prio),
    .pop       (reti),
    .depth     (act_depth),
    .empty     (stk_empty),
    .top_prio  (top_prio)
  );

  assign irq_vec  = best_idx;
  assign irq_prio = best_prio;
  assign irq_addr = addr_q[best_idx];
endmodule

// File: rtl/nvic_checker.sv
module nvic_checker #(
  parameter int NVEC  = 32,
  parameter int PW    = 3,
  parameter int DEPTH = 8,
  parameter int VW    = 5,
  parameter int CW    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            reti,
  input logic            irq_req,
  input logic [VW-1:0]   irq_vec,
  input logic [PW-1:0]   irq_prio,
  input logic [NVEC-1:0] en,
  input logic [NVEC-1:0] pend,
  input logic [CW-1:0]   depth,
  input logic [PW-1:0]   top_prio
);
  AST_REQ_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((depth == '0) || (irq_prio < top_prio))); // R10

  AST_REQ_LIVE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en[irq_vec] && pend[irq_vec])); // R2

  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !reti) |=> (depth == $past(depth) + 1'b1)); // R9

  AST_RETI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && (depth != '0)) |=> (depth == $past(depth) - 1'b1)); // R11

  AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !reti) |=> $stable(depth)); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH)); // R12
endmodule

bind nest_vic nvic_checker #(
  .NVEC(NVEC), .PW(PW), .DEPTH(DEPTH), .VW(VW), .CW(CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ack      (ack),
  .reti     (reti),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .irq_prio (irq_prio),
  .en       (en_q),
  .pend     (pend_q),
  .depth    (act_depth),
  .top_prio (top_prio)
);

// File: tb/nest_vic_test.sv
module nest_vic_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 32;
  localparam int NPRIO = 8;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_fixed = '0, src_dma = '0, src_routed = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_field = '0;
  logic [4:0]  cfg_idx = '0;
  logic [15:0] cfg_data = '0;
  logic        ack = 1'b0, reti = 1'b0;
  logic        irq_req;
  logic [4:0]  irq_vec;
  logic [2:0]  irq_prio;
  logic [15:0] irq_addr;

  int    n_vec = 0, n_bad = 0, wd = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_vic uut (
    .clk(clk), .rst_n(rst_n), .src_fixed(src_fixed), .src_dma(src_dma),
    .src_routed(src_routed), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_prio(irq_prio), .irq_addr(irq_addr)
  );

  // behavioural reference
  int m_en[NVEC], m_pr[NVEC], m_src[NVEC], m_addr[NVEC];
  bit m_pend[NVEC], m_prev[NVEC];
  int m_stk[$];

  function automatic void m_pick(output bit req, output int v, output int p);
    bit f = 0;
    v = 0; p = NPRIO - 1;
    for (int i = 0; i < NVEC; i++)
      if (m_pend[i] && m_en[i] != 0 && (!f || m_pr[i] < p)) begin
        f = 1; v = i; p = m_pr[i];
      end
    req = f && (m_stk.size() == 0 || p < m_stk[$]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVEC; i++) begin
        m_en[i] = 0; m_pr[i] = NPRIO - 1; m_src[i] = 3; m_addr[i] = 0;
        m_pend[i] = 0; m_prev[i] = 0;
      end
      m_stk.delete();
    end else begin
      bit r; int v, p; bit ok; bit ln;
      m_pick(r, v, p);
      ok = ack && !reti && r;
      for (int i = 0; i < NVEC; i++) begin
        case (m_src[i])
          0: ln = src_fixed[i];
          1: ln = src_dma[i];
          2: ln = src_routed[i];
          default: ln = 0;
        endcase
        m_pend[i] = (m_pend[i] && !(ok && v == i)) || (ln && !m_prev[i]) ||
                    (cfg_we && cfg_field == 3 && cfg_idx == i);
        if (cfg_we && cfg_field == 4 && cfg_idx == i) m_pend[i] = 0;
        m_prev[i] = ln;
      end
      if (reti) begin
        if (m_stk.size() > 0) void'(m_stk.pop_back());
      end else if (ok && m_stk.size() < DEPTH) m_stk.push_back(p);
      if (cfg_we)
        case (cfg_field)
          0: m_en[cfg_idx] = cfg_data[0];
          1: m_pr[cfg_idx] = cfg_data[2:0];
          2: m_src[cfg_idx] = cfg_data[1:0];
          5: m_addr[cfg_idx] = cfg_data;
          default: ;
        endcase
    end
  end

  always @(negedge clk) begin
    bit r; int v, p;
    m_pick(r, v, p);
    n_vec++;
    if (irq_req !== r || (r && (irq_vec !== v[4:0] || irq_prio !== p[2:0] ||
                                irq_addr !== m_addr[v][15:0]))) begin
      n_bad++;
      $display("FAIL %s: req=%0b vec=%0d prio=%0d addr=%h, expected req=%0b vec=%0d prio=%0d addr=%h",
               phase, irq_req, irq_vec, irq_prio, irq_addr, r, v, p, m_addr[v]);
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", wd, 20000);
      finish_run();
    end
  end

  task automatic cfg(input int f, input int idx, input int d);
    @(negedge clk); #1;
    cfg_we = 1; cfg_field = f[2:0]; cfg_idx = idx[4:0]; cfg_data = d[15:0];
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic pulse_ack(input bit a, input bit r);
    @(negedge clk); #1; ack = a; reti = r;
    @(posedge clk); #1; ack = 0; reti = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input bit er, input int ev);
    @(negedge clk); #2;
    n_vec++;
    if (irq_req !== er || (er && irq_vec !== ev[4:0])) begin
      n_bad++;
      $display("FAIL %s: req=%0b vec=%0d, expected req=%0b vec=%0d", tag, irq_req, irq_vec, er, ev);
    end
  endtask

  initial begin
    idle(4); #1 rst_n = 1;
    idle(3);
    chk("R1", 0, 0);

    phase = "R13";
    for (int i = 0; i < NVEC; i++) cfg(5, i, 16'h4000 + i * 8);

    phase = "R7";
    cfg(2, 3, 0); cfg(0, 3, 1);
    @(negedge clk); #1 src_dma[3] = 1; idle(2); #1 src_dma[3] = 0;
    chk("R7", 0, 0);
    @(negedge clk); #1 src_fixed[3] = 1;
    idle(1);
    chk("R6", 1, 3);
    cfg(4, 3, 0);
    idle(3);
    chk("R7", 0, 0);
    #1 src_fixed[3] = 0;
    cfg(2, 9, 2); cfg(0, 9, 1);
    @(negedge clk); #1 src_routed[9] = 1; idle(1); #1 src_routed[9] = 0;
    chk("R7", 1, 9);
    cfg(4, 9, 0); cfg(2, 9, 3);
    @(negedge clk); #1 src_routed[9] = 1; idle(1); #1 src_routed[9] = 0;
    chk("R7", 0, 0);

    phase = "R2";
    cfg(2, 5, 1);
    @(negedge clk); #1 src_dma[5] = 1; idle(1); #1 src_dma[5] = 0;
    idle(3);
    chk("R2", 0, 0);
    cfg(0, 5, 1);
    chk("R2", 1, 5);
    cfg(4, 5, 0);

    phase = "R8";
    @(negedge clk); #1;
    src_dma[5] = 1; cfg_we = 1; cfg_field = 3'd4; cfg_idx = 5'd5;
    @(posedge clk); #1 cfg_we = 0;
    idle(1); #1 src_dma[5] = 0;
    chk("R8", 0, 0);

    phase = "R3";
    cfg(1, 20, 5); cfg(1, 21, 2); cfg(1, 22, 2);
    cfg(0, 20, 1); cfg(0, 21, 1); cfg(0, 22, 1);
    cfg(3, 20, 0); cfg(3, 22, 0);
    chk("R3", 1, 22);
    cfg(3, 21, 0);
    chk("R4", 1, 21);
    phase = "R5";
    cfg(1, 22, 1);
    chk("R5", 1, 22);

    phase = "R9";
    pulse_ack(1, 0);
    chk("R10", 0, 0);
    pulse_ack(1, 0);
    chk("R9", 0, 0);
    phase = "R11";
    pulse_ack(0, 1);
    chk("R11", 1, 21);
    pulse_ack(1, 0);
    cfg(1, 23, 0); cfg(0, 23, 1); cfg(3, 23, 0);
    chk("R10", 1, 23);
    pulse_ack(1, 1);
    chk("R11", 1, 23);
    pulse_ack(1, 0);
    pulse_ack(0, 1);
    chk("R11", 1, 20);
    pulse_ack(1, 0);
    pulse_ack(0, 1);
    pulse_ack(0, 1);
    chk("R11", 0, 0);

    phase = "R12";
    for (int k = 0; k < 8; k++) begin
      cfg(1, 10 + k, 7 - k); cfg(0, 10 + k, 1); cfg(3, 10 + k, 0);
      pulse_ack(1, 0);
    end
    cfg(1, 18, 0); cfg(0, 18, 1); cfg(3, 18, 0);
    chk("R12", 0, 0);
    pulse_ack(0, 1);
    chk("R12", 1, 18);
    for (int k = 0; k < 8; k++) pulse_ack(0, 1);
    idle(2);
    finish_run();
  end
endmodule